// File: doc/BRIEF.md
# Four-Character Display Register File

This block holds the stored state of a four-character display controller: four character words and one control word. A host reaches it over an asynchronous, processor-peripheral style bus. The bus has a 3-bit address, separate 8-bit input and output data paths with an output enable, a chip enable of each polarity, and active-low read and write strobes. The block decodes each access, returns read data, and applies the wipe that a control write with its top bit set triggers. It also presents all stored words and a busy flag to the rest of the display logic.

Both strobes pass through two synchronizing flip-flops into the system clock. A write takes effect when its strobe is released, not when it is asserted. Address bit 2 chooses between the character words and the control word. The control word answers at every address with bit 2 low. A wiping control write starts a wait window. For the length of that window every read and write is dropped.

Top module: `disp_regfile`

## Requirements
- R1: An access takes effect only while `sel_n` is 0 and `sel` is 1. With any other pair of levels, writes change nothing and `bus_oe` stays 0.
- R2: A write whose strobe release finds `rd_n` still low is dropped.
- R3: With `bus_addr[2]`=1, `bus_addr[1:0]`=k selects character k (0 is the rightmost digit, 3 the leftmost). The word is 8 bits: bit 7 is the per-digit attribute flag and bits 6:0 are the character code. Character k appears on `char_words[8k+7:8k]` and reads back unchanged.
- R4: With `bus_addr[2]`=0, every value of `bus_addr[1:0]` reaches the one control word. A write through any of these four addresses is read back identically from all four, and `ctrl_word` shows it.
- R5: A control write with bit 7 set stores the written value in the control word and sets all four character words to zero. A later control write with bit 7 clear replaces the control word normally.
- R6: A wiping control write holds `busy` high for exactly CLR_WAIT clock cycles. While `busy` is high, writes are dropped and `bus_oe` stays 0.
- R7: `bus_oe` is 1 two clock edges after a valid read strobe falls, and it returns to 0 within two clock edges after the strobe rises.
- R8: All stored words are zero before the first write, and asserting `rst_n` leaves every stored word unchanged.
- R9: A write updates storage on the third clock edge after `wr_n` rises. Storage is unchanged for as long as `wr_n` is held low.
- R10: A control write with bit 7 clear never raises `busy`, so accesses can follow it back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset for synchronizers and the wait counter |
| bus_addr | input | 3 | Register address |
| bus_din | input | 8 | Write data from the host |
| bus_dout | output | 8 | Read data to the host |
| bus_oe | output | 1 | High while the host data bus is to be driven |
| sel_n | input | 1 | Chip enable, active low |
| sel | input | 1 | Chip enable, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| char_words | output | 32 | The four character words, digit k at bits 8k+7:8k |
| ctrl_word | output | 8 | The stored control word |
| busy | output | 1 | High during the post-wipe wait window |

## Verification
A write lands on the third rising edge after `wr_n` rises. The bench therefore samples storage at the second falling edge after release, where the old value must still hold, and again at the third, where the new value must appear. Read data and `bus_oe` are sampled at the second falling edge after `rd_n` falls. Release is sampled at the second falling edge after `rd_n` rises. The busy window is measured by counting the falling edges at which `busy` is high, and that count must equal CLR_WAIT exactly. Dropped accesses are checked at the ports: the stored words are compared on the outputs after each such access.

// File: rtl/disp_regfile.sv
module disp_regfile #(
  parameter int CLR_WAIT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_din,
  output logic [7:0]  bus_dout,
  output logic        bus_oe,
  input  logic        sel_n,
  input  logic        sel,
  input  logic        rd_n,
  input  logic        wr_n,
  output logic [31:0] char_words,
  output logic [7:0]  ctrl_word,
  output logic        busy
);

  localparam int CW = $clog2(CLR_WAIT + 1);

  logic [2:0]    rd_sync, wr_sync;
  logic [CW-1:0] wait_cnt;
  logic [7:0]    chr [4] = '{default: 8'h00};
  logic [7:0]    ctrl = 8'h00;
  logic          cs_ok, commit, wipe;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_sync <= 3'b111;
      wr_sync <= 3'b111;
    end else begin
      rd_sync <= {rd_sync[1:0], rd_n};
      wr_sync <= {wr_sync[1:0], wr_n};
    end

  assign cs_ok  = ~sel_n & sel;
  assign busy   = wait_cnt != '0;
  assign commit = wr_sync[1] & ~wr_sync[2] & rd_sync[1] & cs_ok & ~busy;
  assign wipe   = commit & ~bus_addr[2] & bus_din[7];

  always_ff @(posedge clk)
    if (commit) begin
      if (bus_addr[2])
        chr[bus_addr[1:0]] <= bus_din;
      else begin
        ctrl <= bus_din;
        if (bus_din[7])
          for (int i = 0; i < 4; i++) chr[i] <= 8'h00;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      wait_cnt <= '0;
    else if (wipe)   wait_cnt <= CW'(CLR_WAIT);
    else if (busy)   wait_cnt <= wait_cnt - 1'b1;

  assign bus_dout  = bus_addr[2] ? chr[bus_addr[1:0]] : ctrl;
  assign bus_oe    = cs_ok & ~rd_sync[1] & wr_sync[1] & ~busy;
  assign ctrl_word = ctrl;

  for (genvar g = 0; g < 4; g++) begin : g_out
    assign char_words[8*g +: 8] = chr[g];
  end

  // R5
  wipe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> char_words == 32'h0);

  // R6
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(char_words) && $stable(ctrl_word)));

  // R7
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_n, 2) |-> !bus_oe);

  // R9
  commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word != $past(ctrl_word)) |-> !$past(wr_n, 4));

  // R9
  char_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_words != $past(char_words) && !$rose(busy)) |-> !$past(wr_n, 4));

endmodule

// File: tb/test_disp_regfile.sv
module test_disp_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT = 30;

  logic        clk = 0, rst_n = 0;
  logic [2:0]  addr = 0;
  logic [7:0]  din = 0, dout;
  logic        oe, sel_n = 1, sel = 0, rd_n = 1, wr_n = 1, busy;
  logic [31:0] chars;
  logic [7:0]  ctrl;
  logic [7:0]  m [4] = '{default: 8'h00};
  int          errs = 0, checks = 0, busy_cycles = 0;

  disp_regfile #(.CLR_WAIT(WAIT)) i_disp_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_din(din), .bus_dout(dout),
    .bus_oe(oe), .sel_n(sel_n), .sel(sel), .rd_n(rd_n), .wr_n(wr_n),
    .char_words(chars), .ctrl_word(ctrl), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (busy) busy_cycles++;

  function automatic logic [31:0] packed_model();
    return {m[3], m[2], m[1], m[0]};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d,
                        input logic cn, input logic cp, input logic also_rd);
    @(negedge clk);
    addr = a; din = d; sel_n = cn; sel = cp; rd_n = ~also_rd; wr_n = 0;
    repeat (3) @(negedge clk);
    wr_n = 1;
    repeat (4) @(negedge clk);
    rd_n = 1; sel_n = 1; sel = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic cn, input logic cp,
                        output logic seen, output logic [7:0] dat, output logic after);
    @(negedge clk);
    addr = a; sel_n = cn; sel = cp; rd_n = 0;
    repeat (2) @(negedge clk);
    seen = oe; dat = dout; rd_n = 1;
    repeat (2) @(negedge clk);
    after = oe; sel_n = 1; sel = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic seen, after;
    logic [7:0] dat, v;
    int b0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    chk(chars, 32'h0, "R8 power-up characters");
    chk(ctrl, 8'h0, "R8 power-up control");
    chk(busy, 1'b0, "R6 idle busy");
    chk(oe, 1'b0, "R7 idle oe");
    for (int a = 0; a < 8; a++) begin
      bus_rd(3'(a), 0, 1, seen, dat, after);
      chk(dat, 8'h0, "R8 power-up readback");
    end

    for (int p = 0; p < 3; p++)
      for (int d = 0; d < 4; d++) begin
        v = 8'(d * 37 + p * 71 + 5);
        m[d] = v;
        bus_wr(3'(4 + d), v, 0, 1, 0);
        chk(chars, packed_model(), "R3 character output");
        bus_rd(3'(4 + d), 0, 1, seen, dat, after);
        chk(seen, 1'b1, "R7 oe during read");
        chk(dat, v, "R3 character readback");
        chk(after, 1'b0, "R7 oe after release");
      end

    @(negedge clk);
    addr = 3'd4; din = 8'h5A; sel_n = 0; sel = 1; wr_n = 0;
    repeat (6) @(negedge clk);
    chk(chars, packed_model(), "R9 held strobe no change");
    wr_n = 1;
    repeat (2) @(negedge clk);
    chk(chars, packed_model(), "R9 two edges after release");
    @(negedge clk);
    m[0] = 8'h5A;
    chk(chars, packed_model(), "R9 third edge after release");
    sel_n = 1; sel = 0;
    repeat (3) @(negedge clk);

    b0 = busy_cycles;
    for (int a = 0; a < 4; a++) begin
      v = 8'(8'h13 + a * 5);
      bus_wr(3'(a), v, 0, 1, 0);
      chk(ctrl, v, "R4 control output");
      chk(busy, 1'b0, "R10 no busy");
      for (int r = 0; r < 4; r++) begin
        bus_rd(3'(r), 0, 1, seen, dat, after);
        chk(dat, v, "R4 mirrored readback");
      end
    end
    chk(busy_cycles - b0, 0, "R10 busy cycles");
    chk(chars, packed_model(), "R4 characters untouched");

    for (int c = 0; c < 3; c++) begin
      logic cn, cp;
      cn = (c != 1);
      cp = (c == 0);
      bus_wr(3'(4 + c), 8'hEE, cn, cp, 0);
      chk(chars, packed_model(), "R1 deselected write");
      bus_rd(3'd5, cn, cp, seen, dat, after);
      chk(seen, 1'b0, "R1 deselected read");
    end

    bus_wr(3'd6, 8'h77, 0, 1, 1);
    chk(chars, packed_model(), "R2 read and write together");

    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(chars, packed_model(), "R8 reset keeps characters");
    chk(ctrl, 8'h22, "R8 reset keeps control");

    b0 = busy_cycles;
    bus_wr(3'd2, 8'h83, 0, 1, 0);
    for (int d = 0; d < 4; d++) m[d] = 8'h00;
    chk(chars, 32'h0, "R5 wipe characters");
    chk(ctrl, 8'h83, "R5 control stored");
    chk(busy, 1'b1, "R6 busy after wipe");
    bus_wr(3'd7, 8'h41, 0, 1, 0);
    chk(chars, 32'h0, "R6 write during busy");
    bus_rd(3'd4, 0, 1, seen, dat, after);
    chk(seen, 1'b0, "R6 read during busy");
    repeat (WAIT + 10) @(negedge clk);
    chk(busy, 1'b0, "R6 busy ends");
    chk(busy_cycles - b0, WAIT, "R6 busy length");

    bus_wr(3'd1, 8'h14, 0, 1, 0);
    chk(ctrl, 8'h14, "R5 second control write");
    bus_wr(3'd5, 8'h4F, 0, 1, 0);
    m[1] = 8'h4F;
    chk(chars, packed_model(), "R5 writes resume");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule